// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder for a 255-Level Flash Converter

This block is the digital back end of a flash converter with 255 comparators. Comparator `i` reads 0 while the sampled input lies above its tap and 1 once it lies below. The comparator word is therefore a thermometer whose low bits are 0 and whose high bits are 1. The number of low bits is the conversion result, from 0 to 255.

Each pair of neighbouring comparator bits is merged into one marker bit of an active-low one-cold bus. That bus is 256 positions wide, with the fixed levels 1 above the top comparator and 0 below the bottom one. A row of sixteen 16-input locators finds the lone 0 within its slice. The low nibble of the result is the OR of their slice positions. A seventeenth locator sees one activity bit per slice and gives the high nibble.

The result is captured in an 8-bit output register on each clock edge where the sample strobe is high. A valid flag marks the cycle after each capture.

Top module: `thermo_flash_encoder`

## Requirements
- R1: With comparator bit `i` equal to 1 exactly when `i >= L`, a capture loads `codeOut = L` for every level L from 1 to 254.
- R2: The internal marker bus holds exactly one 0 when the comparator word is a valid thermometer.
- R3: Levels on slice edges (L mod 16 equal to 0 or 15) encode correctly across all sixteen slices.
- R4: An all-ones comparator word encodes to 0, and an all-zeros word encodes to 255.
- R5: On a clock edge where `sampleStrobe` is low, `codeOut` keeps its previous value whatever the comparator word does.
- R6: `validOut` is 1 in the cycle after each edge that captured a result and 0 after any edge that did not.
- R7: A clock edge with `rst` high clears `codeOut` to 0 and `validOut` to 0, even if `sampleStrobe` is high at that edge.
- R8: `codeOut` changes only at a rising clock edge and is plain unsigned binary, bit 7 being the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleStrobe | input | 1 | Capture the current comparator word at this edge |
| cmpBits | input | 255 | Comparator outputs; bit 0 is the lowest tap |
| codeOut | output | 8 | Registered binary result |
| validOut | output | 1 | High in the cycle after a capture |

## Verification
The marker and slice-activity assertions assume that every captured comparator word is an ideal thermometer: no 1 below a 0, so there is exactly one transition. The encoder merges slice positions by OR, so a word with bubbles would yield a mixed code and trip those checks. The stimulus is therefore built only as ideal thermometers, for every level 0 to 255. Comparator words that change while the strobe is low are also ideal thermometers, so the hold and reset phases stay within the same assumption.

// File: rtl/thermo_enc_pkg.sv
package thermo_enc_pkg;
  localparam int DEF_CMP_COUNT = 255;
  localparam int DEF_SLICE_W   = 16;

  typedef struct packed {
    logic capture;
    logic clear;
  } enc_strobes_t;
endpackage

// File: rtl/slice_locator.sv
module slice_locator #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  coldBus,
  output logic [IW-1:0] pos,
  output logic          allHigh
);
  // OR together the indices of every low bit; with a single 0 this is its index.
  always_comb begin
    pos = '0;
    for (int k = 0; k < W; k++) begin
      if (!coldBus[k]) pos = pos | IW'(k);
    end
    allHigh = &coldBus;
  end
endmodule

// File: rtl/enc_datapath.sv
module enc_datapath
  import thermo_enc_pkg::*;
#(
  parameter int CMP_COUNT = DEF_CMP_COUNT,
  parameter int SLICE_W   = DEF_SLICE_W,
  localparam int POS_N    = CMP_COUNT + 1,
  localparam int IDX_W    = $clog2(SLICE_W),
  localparam int GROUPS   = POS_N / SLICE_W,
  localparam int CODE_W   = $clog2(POS_N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  enc_strobes_t         strobes,
  input  logic [CMP_COUNT-1:0] cmpIn,
  output logic [CODE_W-1:0]    codeQ
);
  logic [POS_N:0]          extBits;
  logic [POS_N-1:0]        oneCold;
  logic [SLICE_W-1:0]      groupAct;
  logic [IDX_W-1:0]        slicePos [GROUPS];
  logic [IDX_W-1:0]        lowNib;
  logic [IDX_W-1:0]        highNib;
  logic                    unusedAll;
  logic [CODE_W-1:0]       codeNext;

  // Fixed 1 above the top comparator, fixed 0 below the bottom one.
  assign extBits = {1'b1, cmpIn, 1'b0};

  genvar j;
  generate
    for (j = 0; j < POS_N; j++) begin : g_marker
      assign oneCold[j] = ~(extBits[j+1] & ~extBits[j]);
    end
  endgenerate

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_slice
      slice_locator #(.W(SLICE_W), .IW(IDX_W)) u_loc (
        .coldBus (oneCold[g*SLICE_W +: SLICE_W]),
        .pos     (slicePos[g]),
        .allHigh (groupAct[g])
      );
    end
    for (g = GROUPS; g < SLICE_W; g++) begin : g_pad
      assign groupAct[g] = 1'b1;
    end
  endgenerate

  always_comb begin
    lowNib = '0;
    for (int k = 0; k < GROUPS; k++) lowNib = lowNib | slicePos[k];
  end

  slice_locator #(.W(SLICE_W), .IW(IDX_W)) u_group_loc (
    .coldBus (groupAct),
    .pos     (highNib),
    .allHigh (unusedAll)
  );

  assign codeNext = CODE_W'({highNib, lowNib});

  always_ff @(posedge clk) begin
    if (strobes.clear)        codeQ <= '0;
    else if (strobes.capture) codeQ <= codeNext;
  end

  // R2: a valid thermometer yields exactly one marker.
  a_r2_single_marker: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |-> ($countones(~oneCold) == 1));

  // R3: exactly one slice reports the marker.
  a_r3_one_group: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |-> ($countones(~groupAct) == 1));

  // R5: without a capture, the register keeps its value.
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(codeQ));

  logic unusedSink;
  assign unusedSink = unusedAll;
endmodule

// File: rtl/enc_control.sv
module enc_control
  import thermo_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleStrobe,
  output enc_strobes_t strobes,
  output logic         validOut
);
  assign strobes.clear   = rst;
  assign strobes.capture = sampleStrobe & ~rst;

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= sampleStrobe;
  end

  // R6: each capture is flagged in the next cycle.
  a_r6_flag_follows: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> validOut);

  // R6: the flag has no other cause.
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(sampleStrobe));
endmodule

// File: rtl/thermo_flash_encoder.sv
module thermo_flash_encoder
  import thermo_enc_pkg::*;
#(
  parameter int CMP_COUNT = DEF_CMP_COUNT,
  parameter int SLICE_W   = DEF_SLICE_W,
  localparam int CODE_W   = $clog2(CMP_COUNT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sampleStrobe,
  input  logic [CMP_COUNT-1:0] cmpBits,
  output logic [CODE_W-1:0]    codeOut,
  output logic                 validOut
);
  enc_strobes_t strobes;

  enc_control u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .strobes      (strobes),
    .validOut     (validOut)
  );

  enc_datapath #(.CMP_COUNT(CMP_COUNT), .SLICE_W(SLICE_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cmpIn   (cmpBits),
    .codeQ   (codeOut)
  );
endmodule

// File: tb/thermo_flash_encoder_bench.sv
module thermo_flash_encoder_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sampleStrobe = 1'b0;
  logic [254:0] cmpBits = '1;
  logic [7:0]   codeOut;
  logic         validOut;

  int    checks = 0;
  int    failures = 0;
  bit    checkOn = 0;
  string phaseTag = "";
  int    expCode = 0;
  bit    expValid = 0;

  thermo_flash_encoder u_thermo_flash_encoder (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .cmpBits      (cmpBits),
    .codeOut      (codeOut),
    .validOut     (validOut)
  );

  always #4 clk = ~clk;

  function automatic logic [254:0] thermo(input int level);
    logic [254:0] v;
    for (int i = 0; i < 255; i++) v[i] = (i >= level);
    return v;
  endfunction

  function automatic int zerosIn(input logic [254:0] v);
    int n = 0;
    for (int i = 0; i < 255; i++) if (!v[i]) n++;
    return n;
  endfunction

  function automatic string codeTag(input int c);
    if (phaseTag != "") return phaseTag;
    if (c == 0 || c == 255) return "R4";
    if ((c % 16) == 0 || (c % 16) == 15) return "R3";
    return "R1";
  endfunction

  // Behavioural reference, updated on the same edges as the design.
  always @(posedge clk) begin
    if (rst) begin
      expCode  <= 0;
      expValid <= 0;
    end else begin
      if (sampleStrobe) expCode <= zerosIn(cmpBits);
      expValid <= sampleStrobe;
    end
  end

  // R8: outputs are compared mid-cycle, away from the edge.
  always @(negedge clk) begin
    if (checkOn) begin
      checks++;
      if (codeOut !== 8'(expCode)) begin
        failures++;
        $display("FAIL %s code actual=%0d expected=%0d", codeTag(expCode), codeOut, expCode);
      end
      checks++;
      if (validOut !== expValid) begin
        failures++;
        $display("FAIL %s valid actual=%0b expected=%0b",
                 (phaseTag != "") ? phaseTag : "R6", validOut, expValid);
      end
    end
  end

  task automatic drive(input bit s, input int level);
    @(posedge clk);
    #2;
    sampleStrobe = s;
    cmpBits = thermo(level);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R7: reset state.
    phaseTag = "R7";
    @(posedge clk);
    checkOn = 1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    phaseTag = "";

    // R1, R3, R4: sweep every level with a capture each cycle.
    for (int lv = 0; lv < 256; lv++) drive(1'b1, lv);
    // R6: strobe gaps.
    for (int lv = 0; lv < 20; lv++) drive(lv[0] ^ lv[2], 255 - lv * 7);

    // R5: level changes with the strobe low must not reach the output.
    drive(1'b1, 77);
    phaseTag = "R5";
    drive(1'b0, 200);
    drive(1'b0, 0);
    drive(1'b0, 255);
    drive(1'b0, 16);
    phaseTag = "";
    drive(1'b1, 255);
    drive(1'b1, 0);

    // R7: reset wins over an active strobe.
    drive(1'b1, 140);
    @(posedge clk);
    #2;
    phaseTag = "R7";
    rst = 1'b1;
    sampleStrobe = 1'b1;
    cmpBits = thermo(99);
    drive(1'b1, 180);
    @(posedge clk);
    #2 rst = 1'b0;
    phaseTag = "";
    drive(1'b1, 31);
    drive(1'b1, 32);
    drive(1'b0, 32);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule